// File: doc/BRIEF.md
# Fill-Level Clock Pull Controller

This block takes audio samples recovered from an incoming digital stream and hands them to a converter that runs on a local pullable crystal clock. The two sides are decoupled by a small dual-clock FIFO, so jitter on the incoming edges never reaches the output timing. Pointers cross between the domains in Gray code through two-stage synchronizers.

A slow servo on the local clock side adds the read-side occupancy into a sum on every cycle of a long fixed window. At the end of each window it compares the sum with a band around the target occupancy. It then moves a signed oscillator control word up one step, down one step, or leaves it where it is. Positive words ask for a faster local clock. One step is meant to be one tenth of a ppm, and the word is held inside a lock range. A wide-lock mode uses a larger step and a wider range so that the block can follow a varispeed source.

The write port uses valid/ready, but the source cannot be stalled. A beat that is offered while `in_ready` is low is lost, and it sets a sticky overflow flag. On the read port, `out_ready` is the converter's sample tick, and every tick takes one word. If no real sample is available, `out_data` is zero and `out_valid` is low. After reset, and after any underflow, the read side holds off. Nothing is taken from the FIFO until the occupancy climbs back to the target, and then output resumes with the oldest stored word.

Top module: `jitter_buffer_pull`

## Requirements
- R1: `in_ready` is high while the FIFO holds fewer than DEPTH (64) words and low when it holds DEPTH words; a beat is stored when `in_valid` and `in_ready` are both high at a `wclk` edge.
- R2: A beat offered while `in_ready` is low is discarded, and `overflow` goes high and stays high until reset.
- R3: Real samples leave in the order they were stored, with none lost or repeated, and `out_valid` is high while `out_data` carries one.
- R4: An `out_ready` tick while the FIFO is empty (outside hold-off) returns `out_data` = 0 with `out_valid` low, and sets `underflow`, which stays high until reset.
- R5: After reset and after any underflow, the read side presents zero with `out_valid` low and removes nothing, until the read-side occupancy reaches TARGET (32); it then resumes with the oldest stored word.
- R6: `ctrl_word` changes only at the last cycle of each INTERVAL-cycle window, with windows counted in `rclk` cycles from reset release.
- R7: If the occupancy summed over a window exceeds (TARGET+HYST)*INTERVAL, the word steps up. If it is below (TARGET-HYST)*INTERVAL, the word steps down. Otherwise it holds, so a steady occupancy of 36 holds, 37 steps up, 28 holds and 27 steps down (HYST = 4).
- R8: The step is STEP when `wide_mode` is low at the decision, and WIDE_STEP when it is high.
- R9: Each decision clamps the result to plus or minus LIMIT (or WIDE_LIMIT in wide mode). `out_of_range` is set by a decision that clamped and cleared by one that did not.
- R10: Each Gray-coded pointer changes at most one bit per clock of its own domain.
- R11: Out of reset, `ctrl_word` is 0, `overflow`, `underflow`, `out_of_range` and `out_valid` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered input sample clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | FIFO has room |
| in_data | input | DW | Input sample |
| rclk | input | 1 | Local crystal clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| out_ready | input | 1 | Converter sample tick |
| out_valid | output | 1 | `out_data` is a real sample |
| out_data | output | DW | Output sample, zero when not valid |
| wide_mode | input | 1 | Selects the wide step and range |
| ctrl_word | output | WW | Signed oscillator control word |
| overflow | output | 1 | Sticky: a beat was dropped |
| underflow | output | 1 | Sticky: a tick found the FIFO empty |
| out_of_range | output | 1 | Last decision was clamped |

## Verification
The bench holds the occupancy exactly at the band edges (36/37 and 28/27), because an off-by-one in the sum compare would step where it should hold. It drives the word into both clamps, then switches from wide mode back to narrow mode while the word lies beyond the narrow range. A design that clamped only on a step, or used the wrong limit, would leave the word out of range or keep the flag wrong. Underflow is followed by a partial refill below target, which catches a design that popped during hold-off and lost or reordered samples. The bench also fills the FIFO to exactly full and offers one more beat, which catches a design that overwrote the oldest word instead of dropping the new one.

// File: rtl/jbp_pkg.sv
package jbp_pkg;
  // Outcome of one averaging window
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;
endpackage

// File: rtl/jbp_sync.sv
module jbp_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/jbp_fifo.sv
module jbp_fifo #(
  parameter int DW     = 24,
  parameter int AW     = 6,
  parameter int TARGET = 32
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          overflow,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          underflow,
  output logic [AW:0]   rd_fill
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] TGT_LVL  = PW'(TARGET);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rgray_w;
  logic [PW-1:0] rbin, rgray, wgray_r;
  logic [PW-1:0] wfill;
  logic          refill, empty;

  // ---------------- write domain ----------------
  assign wfill    = wbin - from_gray(rgray_w);
  assign in_ready = (wfill != FULL_LVL);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      overflow <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
      if (in_valid && !in_ready) overflow <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (in_valid && in_ready) mem[wbin[AW-1:0]] <= in_data;
  end

  jbp_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );
  jbp_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
  );

  // ---------------- read domain ----------------
  assign rd_fill   = from_gray(wgray_r) - rbin;
  assign empty     = (rd_fill == '0);
  assign out_valid = !refill && !empty;
  assign out_data  = out_valid ? mem[rbin[AW-1:0]] : '0;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      refill    <= 1'b1;
      underflow <= 1'b0;
    end else begin
      if (refill && rd_fill >= TGT_LVL) refill <= 1'b0;
      if (out_ready && out_valid) begin
        rbin  <= rbin + 1'b1;
        rgray <= to_gray(rbin + 1'b1);
      end
      if (out_ready && !refill && empty) begin
        underflow <= 1'b1;
        refill    <= 1'b1;
      end
    end
  end

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R2
  ovf_sticky_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    overflow |=> overflow);
  // R4
  unf_sticky_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow |=> underflow);
  // R5
  holdoff_nopop_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    refill |=> $stable(rbin));
  // R4
  empty_nopop_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_ready && empty) |=> $stable(rgray));
endmodule

// File: rtl/jbp_servo.sv
module jbp_servo
  import jbp_pkg::*;
#(
  parameter int FW         = 7,
  parameter int INTERVAL   = 720000,
  parameter int TARGET     = 32,
  parameter int HYST       = 4,
  parameter int WW         = 16,
  parameter int STEP       = 1,
  parameter int LIMIT      = 1500,
  parameter int WIDE_STEP  = 10,
  parameter int WIDE_LIMIT = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FW-1:0]        fill,
  input  logic                 wide_mode,
  output logic signed [WW-1:0] word,
  output logic                 out_of_range
);
  localparam int CW = $clog2(INTERVAL);
  localparam int SW = CW + FW + 1;
  localparam logic [SW-1:0] HI_SUM = SW'((TARGET + HYST) * INTERVAL);
  localparam logic [SW-1:0] LO_SUM = SW'((TARGET - HYST) * INTERVAL);
  localparam logic [CW-1:0] LAST   = CW'(INTERVAL - 1);
  localparam logic signed [WW-1:0] WMAX = WW'(WIDE_LIMIT);

  logic [CW-1:0] cnt;
  logic [SW-1:0] sum, total;
  logic          tick, clip;
  dir_e          dir;
  logic signed [WW+1:0] cand, lim, stepv, nxt;

  assign tick  = (cnt == LAST);
  assign total = sum + SW'(fill);

  always_comb begin
    if (total > HI_SUM)      dir = DIR_UP;
    else if (total < LO_SUM) dir = DIR_DOWN;
    else                     dir = DIR_HOLD;
  end

  always_comb begin
    stepv = wide_mode ? (WW+2)'(WIDE_STEP) : (WW+2)'(STEP);
    lim   = wide_mode ? (WW+2)'(WIDE_LIMIT) : (WW+2)'(LIMIT);
    case (dir)
      DIR_UP:   cand = $signed({{2{word[WW-1]}}, word}) + stepv;
      DIR_DOWN: cand = $signed({{2{word[WW-1]}}, word}) - stepv;
      default:  cand = $signed({{2{word[WW-1]}}, word});
    endcase
    clip = 1'b1;
    if (cand > lim)       nxt = lim;
    else if (cand < -lim) nxt = -lim;
    else begin
      nxt  = cand;
      clip = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      sum          <= '0;
      word         <= '0;
      out_of_range <= 1'b0;
    end else if (tick) begin
      cnt          <= '0;
      sum          <= '0;
      word         <= nxt[WW-1:0];
      out_of_range <= clip;
    end else begin
      cnt <= cnt + 1'b1;
      sum <= total;
    end
  end

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(word) && $stable(out_of_range));
  // R9
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (word <= WMAX) && (word >= -WMAX));
endmodule

// File: rtl/jitter_buffer_pull.sv
module jitter_buffer_pull #(
  parameter int DW         = 24,
  parameter int AW         = 6,
  parameter int TARGET     = 32,
  parameter int HYST       = 4,
  parameter int INTERVAL   = 720000,
  parameter int WW         = 16,
  parameter int STEP       = 1,
  parameter int LIMIT      = 1500,
  parameter int WIDE_STEP  = 10,
  parameter int WIDE_LIMIT = 5000
) (
  input  logic                 wclk,
  input  logic                 wrst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  input  logic                 rclk,
  input  logic                 rrst_n,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data,
  input  logic                 wide_mode,
  output logic signed [WW-1:0] ctrl_word,
  output logic                 overflow,
  output logic                 underflow,
  output logic                 out_of_range
);
  localparam int FW = AW + 1;

  logic [FW-1:0] rd_fill;

  jbp_fifo #(.DW(DW), .AW(AW), .TARGET(TARGET)) u_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .overflow(overflow),
    .rclk(rclk), .rrst_n(rrst_n), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .underflow(underflow), .rd_fill(rd_fill)
  );

  jbp_servo #(
    .FW(FW), .INTERVAL(INTERVAL), .TARGET(TARGET), .HYST(HYST), .WW(WW),
    .STEP(STEP), .LIMIT(LIMIT), .WIDE_STEP(WIDE_STEP), .WIDE_LIMIT(WIDE_LIMIT)
  ) u_servo (
    .clk(rclk), .rst_n(rrst_n), .fill(rd_fill), .wide_mode(wide_mode),
    .word(ctrl_word), .out_of_range(out_of_range)
  );
endmodule

// File: tb/jitter_buffer_pull_tb.sv
module jitter_buffer_pull_tb_top;
  localparam int RCLK_PERIOD = 10;
  localparam int WCLK_PERIOD = 14;
  localparam int DW = 24;
  localparam int IVL = 200;
  localparam int LIM = 3;
  localparam int WLIM = 6;
  localparam int STP = 1;
  localparam int WSTP = 2;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0;
  logic in_valid = 0, out_ready = 0, wide_mode = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, overflow, underflow, out_of_range;
  logic [DW-1:0] out_data;
  logic signed [15:0] ctrl_word;

  int n_vec = 0, n_bad = 0, rcyc = 0, exp_w = 0;
  bit done = 0;
  logic [DW-1:0] sb [$];

  always #(RCLK_PERIOD/2) rclk = ~rclk;
  always #(WCLK_PERIOD/2) wclk = ~wclk;

  always @(posedge rclk or negedge rrst_n)
    if (!rrst_n) rcyc <= 0; else rcyc <= rcyc + 1;

  jitter_buffer_pull #(
    .DW(DW), .AW(6), .TARGET(32), .HYST(4), .INTERVAL(IVL), .WW(16),
    .STEP(STP), .LIMIT(LIM), .WIDE_STEP(WSTP), .WIDE_LIMIT(WLIM)
  ) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rclk(rclk), .rrst_n(rrst_n), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .wide_mode(wide_mode),
    .ctrl_word(ctrl_word), .overflow(overflow), .underflow(underflow),
    .out_of_range(out_of_range)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge rclk);
    rrst_n = 0; wrst_n = 0; in_valid = 0; out_ready = 0; wide_mode = 0;
    sb.delete();
    repeat (4) @(negedge rclk);
    rrst_n = 1;
    @(negedge wclk);
    wrst_n = 1;
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
  endtask

  task automatic push(input logic [DW-1:0] v, output bit acc);
    @(negedge wclk);
    in_valid = 1; in_data = v; acc = in_ready;
    if (acc) sb.push_back(v);
    @(negedge wclk);
    in_valid = 0;
  endtask

  task automatic push_n(input int n, input int base);
    bit a;
    for (int i = 0; i < n; i++) begin
      push(DW'(base + i), a);
      check(a == 1, "R1", a, 1);
    end
  endtask

  // one tick; a real sample must match the scoreboard, a fill-in must be zero
  task automatic pop(input bit want_valid, input bit strict, input string req);
    logic [DW-1:0] d, e;
    bit v;
    @(negedge rclk);
    out_ready = 1; v = out_valid; d = out_data;
    @(negedge rclk);
    out_ready = 0;
    if (strict) check(v == want_valid, req, v, want_valid);
    if (v) begin
      e = (sb.size() > 0) ? sb.pop_front() : '0;
      check(d == e, "R3", int'(d), int'(e));
    end else begin
      check(d == '0, "R4/R5 zero fill-in", int'(d), 0);
    end
  endtask

  task automatic align();
    @(negedge rclk);
    while (rcyc % IVL != 0) @(negedge rclk);
    exp_w = int'(ctrl_word);
  endtask

  // one window at steady occupancy; dir +1/0/-1
  task automatic run_iv(input int dir, input string req);
    int lim, c;
    bit clip;
    lim = wide_mode ? WLIM : LIM;
    c = exp_w + dir * (wide_mode ? WSTP : STP);
    clip = 0;
    if (c > lim) begin c = lim; clip = 1; end
    else if (c < -lim) begin c = -lim; clip = 1; end
    repeat (IVL/2) @(negedge rclk);
    check(int'(ctrl_word) == exp_w, "R6 mid-window", int'(ctrl_word), exp_w);
    repeat (IVL - IVL/2) @(negedge rclk);
    check(int'(ctrl_word) == c, req, int'(ctrl_word), c);
    check(out_of_range == clip, "R9 flag", out_of_range, clip);
    exp_w = c;
  endtask

  initial begin
    #(RCLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    bit a;
    void'($urandom(32'h5eed1234));
    do_reset();
    // R11 reset state
    @(negedge rclk);
    check(in_ready == 1, "R11 in_ready", in_ready, 1);
    check(out_valid == 0, "R11 out_valid", out_valid, 0);
    check(int'(ctrl_word) == 0, "R11 ctrl_word", int'(ctrl_word), 0);
    check(overflow == 0 && underflow == 0 && out_of_range == 0, "R11 flags",
          {overflow, underflow, out_of_range}, 0);
    check(out_data == '0, "R11 out_data", int'(out_data), 0);

    // R5 start-up hold-off below target
    push_n(20, 32'h100);
    settle();
    pop(0, 1, "R5 hold-off");
    check(underflow == 0, "R4 no underflow in hold-off", underflow, 0);
    check(sb.size() == 20, "R5 nothing removed", sb.size(), 20);

    // R1 fill to full, R2 drop
    push_n(44, 32'h200);
    settle();
    check(in_ready == 0, "R1 full", in_ready, 0);
    push(24'hABCDEF, a);
    check(a == 0, "R1 ready low at full", a, 0);
    settle();
    check(overflow == 1, "R2 overflow", overflow, 1);

    // R3 drain in order
    for (int i = 0; i < 64; i++) pop(1, 1, "R3 drain");
    settle();
    check(overflow == 1, "R2 sticky", overflow, 1);

    // R4 underflow
    pop(0, 1, "R4 empty tick");
    check(underflow == 1, "R4 underflow", underflow, 1);

    // R5 recentre after underflow
    push_n(10, 32'h300);
    settle();
    for (int i = 0; i < 3; i++) pop(0, 1, "R5 refill hold");
    push_n(30, 32'h400);
    settle();
    pop(1, 1, "R5 resume oldest");
    for (int i = 0; i < 39; i++) pop(1, 1, "R3 after recentre");
    check(underflow == 1, "R4 sticky", underflow, 1);

    // servo tests
    do_reset();
    push_n(40, 32'h500);
    settle();
    align();
    for (int i = 0; i < 5; i++) run_iv(1, "R7 up / R9 clamp");
    @(negedge rclk); wide_mode = 1;
    exp_w = int'(ctrl_word);
    repeat (IVL - 1) @(negedge rclk);
    exp_w = int'(ctrl_word);
    for (int i = 0; i < 3; i++) run_iv(1, "R8 wide step / R9 wide clamp");
    wide_mode = 0;
    run_iv(1, "R9 narrow clamp after wide");
    for (int i = 0; i < 20; i++) pop(1, 1, "R3");
    settle(); align();
    for (int i = 0; i < 2; i++) run_iv(-1, "R7 down");
    push_n(16, 32'h600);
    settle(); align();
    for (int i = 0; i < 2; i++) run_iv(0, "R7 hold at 36");
    push_n(1, 32'h700);
    settle(); align();
    run_iv(1, "R7 up at 37");
    for (int i = 0; i < 9; i++) pop(1, 1, "R3");
    settle(); align();
    run_iv(0, "R7 hold at 28");
    pop(1, 1, "R3");
    settle(); align();
    run_iv(-1, "R7 down at 27");

    // random traffic
    fork
      begin
        bit ac;
        for (int i = 0; i < 150; i++) begin
          repeat ($urandom_range(0, 2)) @(negedge wclk);
          push(DW'($urandom_range(1, 24'hFFFFFF)), ac);
        end
      end
      begin
        for (int i = 0; i < 150; i++) begin
          repeat ($urandom_range(0, 3)) @(negedge rclk);
          pop(1, 0, "R3 random");
        end
      end
    join
    report();
  end
endmodule